// File: doc/BRIEF.md
# Interrupt Moderation Timer

This block sits on one direction of a DMA completion path and decides when a run of completion events should produce a host interrupt. It holds two counters that share one pending window. The burst counter measures how long the window has been open since its first completion. The idle counter measures the quiet time since the most recent completion. Whichever enabled counter reaches its threshold first ends the window with a single interrupt pulse.

Software programs each counter through a write-only register port. The usual sequence is to clear the counter, write its threshold, and then enable it. A per-counter tick-select bit picks the time base. When the bit is set, the counter advances only on an external microsecond tick, so the threshold reads as microseconds. When the bit is clear, the counter advances on every clock. With neither counter enabled, the block passes every completion straight through as an interrupt.

Top module: `imod_timer`

## Requirements
- R1: After reset `irq_o` is low and both counters are disabled. With no counter enabled, every completion sampled at a clock edge makes `irq_o` high for exactly the cycle after that edge.
- R2: Register address 0 is the burst control register and address 1 is the burst threshold; control bit 0 is enable. With only the burst counter enabled, threshold T>0 and clock time base, `irq_o` is high right after the edge T+1 edges after the edge that sampled the window's first completion. Further completions in the window do not delay it.
- R3: Register address 2 is the idle control register and address 3 is the idle threshold. With only the idle counter enabled, threshold T>0 and clock time base, each completion reloads the idle count to zero. `irq_o` is high right after the edge T+1 edges after the last completion, provided no completion comes in between.
- R4: Each firing produces a one-cycle pulse on `irq_o` and clears both counters and the pending window. A completion on a later edge opens a new window that is timed from scratch.
- R5: When control bit 2 (tick select) is set, the counter advances only at edges where `us_tick_i` is high, so the threshold counts ticks.
- R6: Writing a control register with bit 1 (clear) set zeroes that counter and leaves it disabled, even if bit 0 is set in the same write. If that leaves no counter enabled, the open window is dropped without an interrupt and later completions pass straight through as in R1.
- R7: An enabled counter with threshold zero fires on the completion that would start it, with the same timing as R1.
- R8: With both counters enabled, the one that reaches its threshold first fires. Steady completions spaced closer than the idle threshold are ended by the burst limit, and a quiet gap is ended by the idle limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmpl_i | input | 1 | One-cycle completion event |
| us_tick_i | input | 1 | External microsecond tick, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 burst ctl, 1 burst threshold, 2 idle ctl, 3 idle threshold |
| wr_data_i | input | THR_W | Write data: a threshold, or control bits (0 enable, 1 clear, 2 tick select) |
| irq_o | output | 1 | Moderated interrupt pulse |

## Verification
The assertions check the following on every cycle:
- completions pass straight through when no counter is enabled;
- an interrupt is never raised without a completion or an open window behind it;
- a firing or a clear zeroes the counts;
- a tick-timed counter holds still between ticks;
- the idle count reloads on every completion;
- the burst count keeps climbing through completions.

Only the bench scenarios can show the exact cycle at which each threshold produces the interrupt. They also show the race between the two limits when both are enabled, the restart of a new window after a firing, and the dropping of a window whose counter is cleared mid-count.

// File: rtl/imod_pkg.sv
package imod_pkg;

    localparam int ADDR_W     = 2;
    localparam int NUM_TIMERS = 2;
    localparam int TMR_IDLE   = 1;

    // control register bit positions
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_CLR_BIT  = 1;
    localparam int CTL_TICK_BIT = 2;

    typedef struct packed {
        logic enable;
        logic tick_sel;
    } tmr_ctl_t;

    // each timer owns a control/threshold pair: ctl at 2*i, threshold at 2*i+1
    function automatic logic [ADDR_W-1:0] ctl_addr(input int idx);
        return ADDR_W'(2 * idx);
    endfunction

    function automatic logic [ADDR_W-1:0] thr_addr(input int idx);
        return ADDR_W'(2 * idx + 1);
    endfunction

endpackage

// File: rtl/imod_regs.sv
module imod_regs
    import imod_pkg::*;
#(
    parameter int THR_W = 16
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [THR_W-1:0]                     wr_data,
    output tmr_ctl_t [NUM_TIMERS-1:0]            ctl_o,
    output logic [NUM_TIMERS-1:0][THR_W-1:0]     thr_o,
    output logic [NUM_TIMERS-1:0]                clr_o
);

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_reg
        localparam logic [ADDR_W-1:0] A_CTL = ctl_addr(i);
        localparam logic [ADDR_W-1:0] A_THR = thr_addr(i);

        tmr_ctl_t         ctl_q;
        logic [THR_W-1:0] thr_q;
        logic             ctl_wr;
        logic             thr_wr;

        assign ctl_wr = wr_en && (wr_addr == A_CTL);
        assign thr_wr = wr_en && (wr_addr == A_THR);

        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_q <= '0;
                thr_q <= '0;
            end else begin
                if (ctl_wr) begin
                    ctl_q.enable   <= wr_data[CTL_EN_BIT] & ~wr_data[CTL_CLR_BIT];
                    ctl_q.tick_sel <= wr_data[CTL_TICK_BIT];
                end
                if (thr_wr) begin
                    thr_q <= wr_data;
                end
            end
        end

        assign ctl_o[i] = ctl_q;
        assign thr_o[i] = thr_q;
        assign clr_o[i] = ctl_wr & wr_data[CTL_CLR_BIT];

        AST_CLR_DISABLES: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == A_CTL && wr_data[CTL_CLR_BIT]) |=> !ctl_o[i].enable); // R6
    end

endmodule

// File: rtl/imod_counter.sv
module imod_counter #(
    parameter int THR_W        = 16,
    parameter bit RESTART_EACH = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick_sel,
    input  logic             us_tick,
    input  logic             clr,
    input  logic [THR_W-1:0] thr,
    input  logic             cmpl,
    input  logic             pending,
    input  logic             flush,
    output logic             hit
);

    localparam logic [THR_W-1:0] CNT_MAX = '1;

    logic [THR_W-1:0] cnt_q;
    logic             advance;
    logic             restart;
    logic             wipe;

    assign advance = tick_sel ? us_tick : 1'b1;
    // idle flavour reloads on every completion, burst flavour only when a window opens
    assign restart = RESTART_EACH ? cmpl : (cmpl && !pending);
    assign wipe    = clr || flush || !enable;

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (pending && advance && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = enable && ((pending && (cnt_q >= thr)) || (cmpl && (thr == '0)));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX || cnt_q == '0)); // R2
    AST_WIPE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (clr || flush) |=> (cnt_q == '0)); // R4
    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (enable && tick_sel && !us_tick && !restart && !wipe) |=> $stable(cnt_q)); // R5

    if (RESTART_EACH) begin : g_idle_chk
        AST_IDLE_RELOAD: assert property (@(posedge clk) disable iff (rst)
            (cmpl && enable) |=> (cnt_q == '0)); // R3
    end else begin : g_burst_chk
        AST_BURST_KEEPS: assert property (@(posedge clk) disable iff (rst)
            (enable && pending && cmpl && !flush && !clr && !tick_sel && cnt_q != CNT_MAX)
            |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
    end

endmodule

// File: rtl/imod_fire.sv
module imod_fire
    import imod_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmpl,
    input  logic                  any_en,
    input  logic [NUM_TIMERS-1:0] hit,
    output logic                  pending,
    output logic                  fire,
    output logic                  irq
);

    logic pending_q;
    logic irq_q;

    assign fire = any_en ? (|hit) : cmpl;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            pending_q <= any_en && !fire && (pending_q || cmpl);
            irq_q     <= fire;
        end
    end

    assign pending = pending_q;
    assign irq     = irq_q;

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (!any_en && cmpl) |=> irq); // R1
    AST_FIRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        irq |-> !pending_q); // R4
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(cmpl || pending_q)); // R4
    AST_DROP_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !any_en |=> !pending_q); // R6

endmodule

// File: rtl/imod_timer.sv
module imod_timer
    import imod_pkg::*;
#(
    parameter int THR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmpl_i,
    input  logic              us_tick_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [THR_W-1:0]  wr_data_i,
    output logic              irq_o
);

    tmr_ctl_t [NUM_TIMERS-1:0]        ctl;
    logic [NUM_TIMERS-1:0][THR_W-1:0] thr;
    logic [NUM_TIMERS-1:0]            clr;
    logic [NUM_TIMERS-1:0]            hit;
    logic                             any_en;
    logic                             pending;
    logic                             fire;

    imod_regs #(.THR_W(THR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .wr_data (wr_data_i),
        .ctl_o   (ctl),
        .thr_o   (thr),
        .clr_o   (clr)
    );

    always_comb begin
        any_en = 1'b0;
        for (int k = 0; k < NUM_TIMERS; k++) begin
            any_en = any_en | ctl[k].enable;
        end
    end

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
        imod_counter #(
            .THR_W        (THR_W),
            .RESTART_EACH ((i == TMR_IDLE) ? 1'b1 : 1'b0)
        ) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .enable   (ctl[i].enable),
            .tick_sel (ctl[i].tick_sel),
            .us_tick  (us_tick_i),
            .clr      (clr[i]),
            .thr      (thr[i]),
            .cmpl     (cmpl_i),
            .pending  (pending),
            .flush    (fire),
            .hit      (hit[i])
        );
    end

    imod_fire u_fire (
        .clk     (clk),
        .rst     (rst),
        .cmpl    (cmpl_i),
        .any_en  (any_en),
        .hit     (hit),
        .pending (pending),
        .fire    (fire),
        .irq     (irq_o)
    );

endmodule

// File: tb/imod_timer_bench.sv
`timescale 1ns/1ps
module imod_timer_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmpl;
    logic        us_tick;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    imod_timer #(.THR_W(16)) u_imod_timer (
        .clk       (clk),
        .rst       (rst),
        .cmpl_i    (cmpl),
        .us_tick_i (us_tick),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .irq_o     (irq)
    );

    // vectors: burst en/thr, idle en/thr, tick period (0 = clock), completions, gap,
    // expected first irq cycle, expected irq-high cycles
    localparam int NV = 10;
    localparam int V_BEN [NV] = '{0, 0, 1,  0, 1,  1, 1, 1, 0, 0};
    localparam int V_BTHR[NV] = '{0, 0, 10, 0, 20, 6, 0, 3, 0, 0};
    localparam int V_IEN [NV] = '{0, 0, 0,  1, 1,  1, 0, 0, 1, 1};
    localparam int V_ITHR[NV] = '{0, 0, 0,  5, 4,  4, 0, 0, 2, 0};
    localparam int V_TICK[NV] = '{0, 0, 0,  0, 0,  0, 0, 4, 4, 0};
    localparam int V_NC  [NV] = '{1, 3, 6,  4, 3,  5, 3, 1, 1, 1};
    localparam int V_GAP [NV] = '{1, 2, 2,  3, 2,  2, 2, 1, 1, 1};
    localparam int V_DLY [NV] = '{0, 0, 11, 15, 9, 7, 0, 11, 7, 0};
    localparam int V_HI  [NV] = '{1, 3, 1,  1, 1,  2, 3, 1, 1, 1};

    function automatic string vec_req(input int idx);
        case (idx)
            0, 1:    return "R1";
            2:       return "R2";
            3:       return "R3";
            4:       return "R8";
            5:       return "R4";
            6, 9:    return "R7";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    // ctl bits: 0 enable, 1 clear, 2 tick select (R2, R3, R5, R6)
    task automatic configure(input int ben, input int bthr, input int ien, input int ithr, input int tickp);
        logic [15:0] tbit;
        tbit = (tickp != 0) ? 16'd4 : 16'd0;
        reg_wr(2'd0, 16'd2);
        reg_wr(2'd2, 16'd2);
        reg_wr(2'd1, 16'(bthr));
        reg_wr(2'd3, 16'(ithr));
        reg_wr(2'd0, 16'(ben) | tbit);
        reg_wr(2'd2, 16'(ien) | tbit);
    endtask

    task automatic run_window(input int nc, input int gap, input int tickp, input int clr_at,
                              output int first, output int hi);
        first = -1;
        hi    = 0;
        for (int c = 0; c < 40; c++) begin
            cmpl    = (c < nc * gap) && (c % gap == 0);
            us_tick = (tickp != 0) && (c % tickp == 2);
            if (c == clr_at) begin
                wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'd2;
            end else begin
                wr_en = 1'b0;
            end
            @(posedge clk); @(negedge clk);
            if (irq) begin
                hi++;
                if (first < 0) first = c;
            end
        end
        cmpl = 1'b0; us_tick = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog: actual 1 expected 0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int first;
        int hi;
        rst = 1'b1; cmpl = 1'b0; us_tick = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1", "irq after reset", int'(irq), 0);
        run_window(0, 1, 0, -1, first, hi);
        check("R1", "irq with no completions", hi, 0);

        for (int v = 0; v < NV; v++) begin
            configure(V_BEN[v], V_BTHR[v], V_IEN[v], V_ITHR[v], V_TICK[v]);
            run_window(V_NC[v], V_GAP[v], V_TICK[v], -1, first, hi);
            check(vec_req(v), $sformatf("vector %0d first irq cycle", v), first, V_DLY[v]);
            check(vec_req(v), $sformatf("vector %0d irq high cycles", v), hi, V_HI[v]);
        end

        // R6: clear burst counter mid-window drops the window
        configure(1, 10, 0, 0, 0);
        run_window(1, 1, 0, 3, first, hi);
        check("R6", "irq after mid-window clear", hi, 0);
        run_window(1, 1, 0, -1, first, hi);
        check("R6", "pass-through delay after clear", first, 0);
        check("R6", "pass-through pulses after clear", hi, 1);

        // R6: clear together with enable leaves the counter disabled
        configure(0, 10, 0, 0, 0);
        reg_wr(2'd0, 16'd3);
        run_window(1, 1, 0, -1, first, hi);
        check("R6", "clear+enable write delay", first, 0);

        // R4: new window after a firing is timed from scratch
        configure(1, 5, 0, 0, 0);
        run_window(1, 1, 0, -1, first, hi);
        check("R4", "first window delay", first, 6);
        run_window(1, 1, 0, -1, first, hi);
        check("R4", "second window delay", first, 6);
        check("R4", "second window pulses", hi, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule